// File: doc/BRIEF.md
# Tagged Joint Address Translation Buffer

This block is a fully associative buffer that translates virtual addresses into physical addresses. It serves both instruction and data translations. Each of its N entries covers two neighbouring virtual pages, one even and one odd. Each entry holds a page-pair tag (the virtual page-pair number, VPN2), an address-space tag (ASID), a size mask, and a separate frame word for each half. The page size is set per entry, from 4 KiB up to 16 KiB, 64 KiB, 256 KiB, 1 MiB, 4 MiB or 16 MiB. Two tasks with the same virtual page but different ASIDs can therefore hold entries at the same time.

Software loads a whole entry in one write cycle. The write presents the slot number, the tag, the two frame words and the size mask together. Software can read any slot back. The lookup port takes a virtual address, the current ASID and a store flag. One cycle later it returns the translated physical address, a hit flag, the valid bit, the dirty bit and the cache attribute of the selected page, plus a fault code.

Top module: `jtlb`

## Requirements
- R1: After reset every slot is empty. Any lookup misses, readback of any slot returns all-zero fields, and `res_valid` is low until a lookup is issued.
- R2: A write with `wr_en` high stores the tag, the ASID, the mask and both frame words into slot `wr_index`. The frame word layout is: bit 0 global, bit 1 valid, bit 2 dirty, bits 5:3 cache attribute, bits 25:6 frame number. Readback appears one cycle after `rd_index` is presented. Bit 0 of both read-back frame words equals the AND of the two written global bits.
- R3: A lookup presented with `lk_valid` high produces its result with `res_valid` high in the next cycle. `res_valid` is low in every cycle that does not follow a lookup.
- R4: A slot matches only when the VPN2 (address bits 31:13) agrees outside the masked bits and the ASID agrees. Slots with equal VPN2 but different ASIDs coexist, and each returns its own frame.
- R5: When both global bits of a slot were written as 1, the slot ignores the ASID. When only one of them was 1, the ASID is still compared.
- R6: Mask bit i excludes VPN2 bit i (address bit 13+i) from the compare. The legal masks are 0x000, 0x003, 0x00F, 0x03F, 0x0FF, 0x3FF and 0xFFF, for 4K up to 16M pages. With k set mask bits, address bit 12+k selects the odd half (1) or the even half (0). The physical address is the frame number shifted left by 12, with its low 12+k bits replaced by the same bits of the virtual address.
- R7: The fault code `res_fault` is 1 on a miss, 2 on a hit of a page with the valid bit 0, 3 on a store to a valid page with the dirty bit 0, and 0 otherwise. On a miss, `res_pa`, `res_v`, `res_d` and `res_cattr` are zero.
- R8: A lookup issued in the same cycle as a write sees the slot contents from before that write. A lookup issued in the following cycle sees the new contents.
- R9: When more than one slot matches, the slot with the lowest index supplies the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write one slot this cycle |
| wr_index | input | IDX_W | Slot to write |
| wr_vpn2 | input | VPN2_W | Page-pair tag (address bits 31:13) |
| wr_asid | input | ASID_W | Address space tag |
| wr_lo0 | input | LO_W | Even-page frame word |
| wr_lo1 | input | LO_W | Odd-page frame word |
| wr_mask | input | MASK_W | Page size mask |
| rd_index | input | IDX_W | Slot to read back |
| rd_vpn2 | output | VPN2_W | Read-back tag |
| rd_asid | output | ASID_W | Read-back ASID |
| rd_lo0 | output | LO_W | Read-back even frame word |
| rd_lo1 | output | LO_W | Read-back odd frame word |
| rd_mask | output | MASK_W | Read-back size mask |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | VA_W | Virtual address to translate |
| lk_asid | input | ASID_W | Current address space |
| lk_store | input | 1 | Lookup is for a store |
| res_valid | output | 1 | Result present |
| res_hit | output | 1 | A slot matched |
| res_pa | output | PA_W | Physical address |
| res_v | output | 1 | Valid bit of the selected page |
| res_d | output | 1 | Dirty bit of the selected page |
| res_cattr | output | 3 | Cache attribute of the selected page |
| res_fault | output | 2 | Fault code, see R7 |

## Verification
The assertions check on every cycle the one-cycle result timing and how the fault code agrees with the hit, valid, dirty and store flags. That agreement covers the zero outputs on a miss and the rule that a modify fault only follows a store. Only the bench's scenarios can show the translation itself. These are the address arithmetic for every page size and half, the ASID and global matching, the coexistence of same-VPN2 slots, lowest-index priority, readback contents, and the order in which a write and a lookup in the same cycle take effect. The bench compares each of these against its own arithmetic model.

// File: rtl/tlb_pkg.sv
// Shared encodings for the translation buffer.
// Assumes a 4 KiB minimum page and a pair tag that starts at address bit 13.
package tlb_pkg;
    localparam int PAGE_SHIFT = 12;
    localparam int VPN2_LSB   = PAGE_SHIFT + 1;
    // frame word field positions
    localparam int LO_G       = 0;
    localparam int LO_V       = 1;
    localparam int LO_D       = 2;
    localparam int LO_C_LSB   = 3;
    localparam int LO_C_W     = 3;
    localparam int LO_PFN_LSB = 6;
    // attribute bundle {c, d, v} taken from frame word bits 5:1
    localparam int ATTR_W     = LO_C_W + 2;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_MISS    = 2'd1,
        FLT_INVALID = 2'd2,
        FLT_MODIFY  = 2'd3
    } tlb_fault_e;
endpackage

// File: rtl/tlb_slot.sv
// One buffer slot: storage, tag compare, even/odd selection and address
// composition for its own contents.
// Assumes the mask holds only legal values (low bits set in pairs).
module tlb_slot
    import tlb_pkg::*;
#(
    parameter int VPN2_W = 19,
    parameter int ASID_W = 8,
    parameter int MASK_W = 12,
    parameter int PFN_W  = 20
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [VPN2_W-1:0]            wr_vpn2,
    input  logic [ASID_W-1:0]            wr_asid,
    input  logic [PFN_W+LO_PFN_LSB-1:0]  wr_lo0,
    input  logic [PFN_W+LO_PFN_LSB-1:0]  wr_lo1,
    input  logic [MASK_W-1:0]            wr_mask,
    input  logic [VPN2_W+VPN2_LSB-1:0]   lk_va,
    input  logic [ASID_W-1:0]            lk_asid,
    output logic                         match,
    output logic [ATTR_W-1:0]            page_attr,
    output logic [PFN_W+PAGE_SHIFT-1:0]  page_pa,
    output logic [VPN2_W-1:0]            st_vpn2,
    output logic [ASID_W-1:0]            st_asid,
    output logic [PFN_W+LO_PFN_LSB-1:0]  st_lo0,
    output logic [PFN_W+LO_PFN_LSB-1:0]  st_lo1,
    output logic [MASK_W-1:0]            st_mask
);
    localparam int LO_W = PFN_W + LO_PFN_LSB;
    localparam int VA_W = VPN2_W + VPN2_LSB;
    localparam int PA_W = PFN_W + PAGE_SHIFT;

    logic              filled_q, glob_q;
    logic [VPN2_W-1:0] vpn2_q;
    logic [ASID_W-1:0] asid_q;
    logic [MASK_W-1:0] mask_q;
    logic [LO_W-1:1]   lo0_q, lo1_q;

    // Purpose: hold the slot contents, cleared to empty at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filled_q <= 1'b0;
            glob_q   <= 1'b0;
            vpn2_q   <= '0;
            asid_q   <= '0;
            mask_q   <= '0;
            lo0_q    <= '0;
            lo1_q    <= '0;
        end else if (we) begin
            filled_q <= 1'b1;
            glob_q   <= wr_lo0[LO_G] & wr_lo1[LO_G];
            vpn2_q   <= wr_vpn2;
            asid_q   <= wr_asid;
            mask_q   <= wr_mask;
            lo0_q    <= wr_lo0[LO_W-1:1];
            lo1_q    <= wr_lo1[LO_W-1:1];
        end
    end

    // Purpose: one-hot pick of the address bit that chooses the odd half.
    logic [MASK_W:0] sel;
    for (genvar p = 0; p <= MASK_W; p++) begin : g_sel
        if (p == 0) begin : g_lo
            assign sel[p] = ~mask_q[0];
        end else if (p == MASK_W) begin : g_hi
            assign sel[p] = mask_q[MASK_W-1];
        end else begin : g_mid
            assign sel[p] = mask_q[p-1] & ~mask_q[p];
        end
    end

    logic              odd, vpn_ok, asid_ok;
    logic [VPN2_W-1:0] cmp_keep;
    logic [PFN_W-1:0]  pfn;
    logic [PA_W-1:0]   off_mask, frame, va_low;

    // Purpose: tag compare, half selection and physical address merge.
    always_comb begin
        cmp_keep  = ~{{(VPN2_W-MASK_W){1'b0}}, mask_q};
        vpn_ok    = ((lk_va[VA_W-1:VPN2_LSB] ^ vpn2_q) & cmp_keep) == '0;
        asid_ok   = glob_q || (lk_asid == asid_q);
        match     = filled_q && vpn_ok && asid_ok;
        odd       = |(sel & lk_va[PAGE_SHIFT +: MASK_W+1]);
        page_attr = odd ? lo1_q[LO_PFN_LSB-1:1] : lo0_q[LO_PFN_LSB-1:1];
        pfn       = odd ? lo1_q[LO_W-1:LO_PFN_LSB] : lo0_q[LO_W-1:LO_PFN_LSB];
        frame     = {pfn, {PAGE_SHIFT{1'b0}}};
        off_mask  = {{(PA_W-PAGE_SHIFT-MASK_W){1'b0}}, mask_q, {PAGE_SHIFT{1'b1}}};
        va_low    = {{(PA_W-PAGE_SHIFT-MASK_W){1'b0}}, lk_va[MASK_W+PAGE_SHIFT-1:0]};
        page_pa   = (frame & ~off_mask) | (va_low & off_mask);
    end

    // Purpose: present stored contents for readback, global bit in both words.
    always_comb begin
        st_vpn2 = vpn2_q;
        st_asid = asid_q;
        st_mask = mask_q;
        st_lo0  = {lo0_q, glob_q};
        st_lo1  = {lo1_q, glob_q};
    end
endmodule

// File: rtl/tlb_pick.sv
// Priority selection among matching slots: the lowest index wins.
// Assumes per-slot attribute and address are already resolved.
module tlb_pick
    import tlb_pkg::*;
#(
    parameter int N    = 16,
    parameter int PA_W = 32
) (
    input  logic [N-1:0]      match,
    input  logic [ATTR_W-1:0] attr_in [N],
    input  logic [PA_W-1:0]   pa_in   [N],
    output logic              hit,
    output logic [ATTR_W-1:0] attr,
    output logic [PA_W-1:0]   pa
);
    // Purpose: scan from the top so the lowest matching index is applied last.
    always_comb begin
        hit  = |match;
        attr = '0;
        pa   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) begin
                attr = attr_in[i];
                pa   = pa_in[i];
            end
        end
    end
endmodule

// File: rtl/jtlb.sv
// Joint translation buffer top: slot array, write decode, readback port and
// registered lookup result with fault classification.
// Assumes legal page masks; an index at or above N writes and reads nothing.
module jtlb
    import tlb_pkg::*;
#(
    parameter int N      = 16,
    parameter int VPN2_W = 19,
    parameter int ASID_W = 8,
    parameter int MASK_W = 12,
    parameter int PFN_W  = 20,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1,
    localparam int LO_W  = PFN_W + LO_PFN_LSB,
    localparam int VA_W  = VPN2_W + VPN2_LSB,
    localparam int PA_W  = PFN_W + PAGE_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_index,
    input  logic [VPN2_W-1:0] wr_vpn2,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [LO_W-1:0]   wr_lo0,
    input  logic [LO_W-1:0]   wr_lo1,
    input  logic [MASK_W-1:0] wr_mask,
    input  logic [IDX_W-1:0]  rd_index,
    output logic [VPN2_W-1:0] rd_vpn2,
    output logic [ASID_W-1:0] rd_asid,
    output logic [LO_W-1:0]   rd_lo0,
    output logic [LO_W-1:0]   rd_lo1,
    output logic [MASK_W-1:0] rd_mask,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_store,
    output logic              res_valid,
    output logic              res_hit,
    output logic [PA_W-1:0]   res_pa,
    output logic              res_v,
    output logic              res_d,
    output logic [2:0]        res_cattr,
    output logic [1:0]        res_fault
);
    logic [N-1:0]      hit_vec;
    logic [ATTR_W-1:0] s_attr [N];
    logic [PA_W-1:0]   s_pa   [N];
    logic [VPN2_W-1:0] s_vpn2 [N];
    logic [ASID_W-1:0] s_asid [N];
    logic [LO_W-1:0]   s_lo0  [N];
    logic [LO_W-1:0]   s_lo1  [N];
    logic [MASK_W-1:0] s_mask [N];

    for (genvar i = 0; i < N; i++) begin : g_slot
        tlb_slot #(
            .VPN2_W(VPN2_W), .ASID_W(ASID_W), .MASK_W(MASK_W), .PFN_W(PFN_W)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .we       (wr_en && (wr_index == IDX_W'(i))),
            .wr_vpn2  (wr_vpn2),
            .wr_asid  (wr_asid),
            .wr_lo0   (wr_lo0),
            .wr_lo1   (wr_lo1),
            .wr_mask  (wr_mask),
            .lk_va    (lk_va),
            .lk_asid  (lk_asid),
            .match    (hit_vec[i]),
            .page_attr(s_attr[i]),
            .page_pa  (s_pa[i]),
            .st_vpn2  (s_vpn2[i]),
            .st_asid  (s_asid[i]),
            .st_lo0   (s_lo0[i]),
            .st_lo1   (s_lo1[i]),
            .st_mask  (s_mask[i])
        );
    end

    logic              any_hit;
    logic [ATTR_W-1:0] sel_attr;
    logic [PA_W-1:0]   sel_pa;

    tlb_pick #(.N(N), .PA_W(PA_W)) u_pick (
        .match  (hit_vec),
        .attr_in(s_attr),
        .pa_in  (s_pa),
        .hit    (any_hit),
        .attr   (sel_attr),
        .pa     (sel_pa)
    );

    tlb_fault_e fault_c;

    // Purpose: classify the lookup outcome from hit, valid, dirty and store.
    always_comb begin
        if (!any_hit)
            fault_c = FLT_MISS;
        else if (!sel_attr[0])
            fault_c = FLT_INVALID;
        else if (lk_store && !sel_attr[1])
            fault_c = FLT_MODIFY;
        else
            fault_c = FLT_NONE;
    end

    // Purpose: register the lookup result, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_pa    <= '0;
            res_v     <= 1'b0;
            res_d     <= 1'b0;
            res_cattr <= '0;
            res_fault <= '0;
        end else begin
            res_valid <= lk_valid;
            if (lk_valid) begin
                res_hit   <= any_hit;
                res_pa    <= sel_pa;
                res_v     <= sel_attr[0];
                res_d     <= sel_attr[1];
                res_cattr <= sel_attr[ATTR_W-1:2];
                res_fault <= fault_c;
            end
        end
    end

    logic [VPN2_W-1:0] rb_vpn2;
    logic [ASID_W-1:0] rb_asid;
    logic [LO_W-1:0]   rb_lo0, rb_lo1;
    logic [MASK_W-1:0] rb_mask;

    // Purpose: select the slot addressed by the readback index.
    always_comb begin
        rb_vpn2 = '0;
        rb_asid = '0;
        rb_lo0  = '0;
        rb_lo1  = '0;
        rb_mask = '0;
        for (int i = 0; i < N; i++) begin
            if (rd_index == IDX_W'(i)) begin
                rb_vpn2 = s_vpn2[i];
                rb_asid = s_asid[i];
                rb_lo0  = s_lo0[i];
                rb_lo1  = s_lo1[i];
                rb_mask = s_mask[i];
            end
        end
    end

    // Purpose: register the readback fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_vpn2 <= '0;
            rd_asid <= '0;
            rd_lo0  <= '0;
            rd_lo1  <= '0;
            rd_mask <= '0;
        end else begin
            rd_vpn2 <= rb_vpn2;
            rd_asid <= rb_asid;
            rd_lo0  <= rb_lo0;
            rd_lo1  <= rb_lo1;
            rd_mask <= rb_mask;
        end
    end
endmodule

// File: rtl/jtlb_chk.sv
// Cycle-level properties of the lookup result, bound into every jtlb.
module jtlb_chk #(
    parameter int PA_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            lk_valid,
    input logic            lk_store,
    input logic            res_valid,
    input logic            res_hit,
    input logic [PA_W-1:0] res_pa,
    input logic            res_v,
    input logic            res_d,
    input logic [2:0]      res_cattr,
    input logic [1:0]      res_fault
);
    a_r3_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);
    a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_valid);
    a_r7_miss_code: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (res_fault == 2'd1));
    a_r7_hit_code: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_hit) |-> (res_fault != 2'd1));
    a_r7_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (res_pa == '0 && !res_v && !res_d && res_cattr == 3'd0));
    a_r7_invalid_page: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault == 2'd2) |-> !res_v);
    a_r7_modify_store: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault == 2'd3) |-> ($past(lk_store) && res_v && !res_d));
endmodule

bind jtlb jtlb_chk #(.PA_W(PA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_valid (lk_valid),
    .lk_store (lk_store),
    .res_valid(res_valid),
    .res_hit  (res_hit),
    .res_pa   (res_pa),
    .res_v    (res_v),
    .res_d    (res_d),
    .res_cattr(res_cattr),
    .res_fault(res_fault)
);

// File: tb/jtlb_test.sv
`timescale 1ns/1ps
module jtlb_test;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_index = '0;
    logic [18:0] wr_vpn2 = '0;
    logic [7:0]  wr_asid = '0;
    logic [25:0] wr_lo0 = '0, wr_lo1 = '0;
    logic [11:0] wr_mask = '0;
    logic [3:0]  rd_index = '0;
    logic [18:0] rd_vpn2;
    logic [7:0]  rd_asid;
    logic [25:0] rd_lo0, rd_lo1;
    logic [11:0] rd_mask;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_va = '0;
    logic [7:0]  lk_asid = '0;
    logic        lk_store = 1'b0;
    logic        res_valid, res_hit, res_v, res_d;
    logic [31:0] res_pa;
    logic [2:0]  res_cattr;
    logic [1:0]  res_fault;

    always #4 clk = ~clk;

    jtlb uut (.*);

    int total = 0, bad = 0;
    bit done = 0;

    // bench model of slot contents
    logic        m_fill [N];
    logic [18:0] m_vpn2 [N];
    logic [7:0]  m_asid [N];
    logic [25:0] m_lo0  [N];
    logic [25:0] m_lo1  [N];
    logic [11:0] m_mask [N];

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [25:0] mk_lo(input logic [19:0] pfn, input logic [2:0] c,
                                          input logic d, input logic v, input logic g);
        return {pfn, c, d, v, g};
    endfunction

    // R4 R5 R6 R7 R9 arithmetic model of one lookup
    task automatic model(input logic [31:0] va, input logic [7:0] asid, input logic st,
                         output logic hit, output logic [31:0] pa, output logic v,
                         output logic d, output logic [2:0] c, output logic [1:0] flt);
        hit = 0; pa = 0; v = 0; d = 0; c = 0; flt = 2'd1;
        for (int i = 0; i < N; i++) begin
            int k;
            logic [18:0] keep;
            logic [25:0] lo;
            logic [31:0] offm;
            logic g;
            if (hit || !m_fill[i]) continue;
            k = $countones(m_mask[i]);
            keep = ~{7'd0, m_mask[i]};
            g = m_lo0[i][0] & m_lo1[i][0];
            if (((va[31:13] ^ m_vpn2[i]) & keep) != 0) continue;
            if (!g && asid != m_asid[i]) continue;
            hit = 1;
            lo = va[12 + k] ? m_lo1[i] : m_lo0[i];
            offm = (32'd1 << (12 + k)) - 1;
            pa = ({lo[25:6], 12'd0} & ~offm) | (va & offm);
            v = lo[1]; d = lo[2]; c = lo[5:3];
            flt = !v ? 2'd2 : (st && !d) ? 2'd3 : 2'd0;
        end
    endtask

    task automatic wr(input int idx, input logic [18:0] vpn2, input logic [7:0] asid,
                      input logic [25:0] lo0, input logic [25:0] lo1, input logic [11:0] mask);
        wr_en = 1; wr_index = idx[3:0]; wr_vpn2 = vpn2; wr_asid = asid;
        wr_lo0 = lo0; wr_lo1 = lo1; wr_mask = mask;
        @(negedge clk);
        wr_en = 0;
        m_fill[idx] = 1; m_vpn2[idx] = vpn2; m_asid[idx] = asid;
        m_lo0[idx] = lo0; m_lo1[idx] = lo1; m_mask[idx] = mask;
    endtask

    task automatic look(input string req, input logic [31:0] va, input logic [7:0] asid,
                        input logic st);
        logic h, v, d; logic [31:0] pa; logic [2:0] c; logic [1:0] f;
        model(va, asid, st, h, pa, v, d, c, f);
        lk_valid = 1; lk_va = va; lk_asid = asid; lk_store = st;
        @(negedge clk);
        lk_valid = 0;
        chk({req, " valid"}, 64'(res_valid), 64'd1);
        chk({req, " hit"}, 64'(res_hit), 64'(h));
        chk({req, " pa"}, 64'(res_pa), 64'(pa));
        chk({req, " attr"}, 64'({res_cattr, res_d, res_v}), 64'({c, d, v}));
        chk({req, " fault"}, 64'(res_fault), 64'(f));
    endtask

    task automatic readback(input string req, input int idx);
        logic g;
        rd_index = idx[3:0];
        @(negedge clk);
        g = m_lo0[idx][0] & m_lo1[idx][0];
        chk({req, " rd_vpn2"}, 64'(rd_vpn2), 64'(m_vpn2[idx]));
        chk({req, " rd_asid"}, 64'(rd_asid), 64'(m_asid[idx]));
        chk({req, " rd_mask"}, 64'(rd_mask), 64'(m_mask[idx]));
        chk({req, " rd_lo0"}, 64'(rd_lo0), 64'({m_lo0[idx][25:1], g}));
        chk({req, " rd_lo1"}, 64'(rd_lo1), 64'({m_lo1[idx][25:1], g}));
    endtask

    function automatic logic [11:0] size_mask(input int s);
        return 12'((1 << (2 * s)) - 1);
    endfunction

    initial begin
        for (int i = 0; i < N; i++) begin
            m_fill[i] = 0; m_vpn2[i] = 0; m_asid[i] = 0;
            m_lo0[i] = 0; m_lo1[i] = 0; m_mask[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk("R1 res_valid after reset", 64'(res_valid), 64'd0);
        for (int i = 0; i < N; i++) readback("R1 empty", i);
        look("R1 empty miss", 32'h0000_0000, 8'd0, 1'b0);
        look("R1 empty miss high", 32'hA000_1234, 8'd5, 1'b1);

        // R2 R6: fill every slot, page sizes cycling through all seven
        for (int i = 0; i < N; i++) begin
            logic [19:0] p0;
            p0 = 20'h80000 | 20'(i << 8) | 20'h00033;
            wr(i, 19'(i << 12), 8'(i + 3),
               mk_lo(p0, 3'(i), 1'b1, 1'b1, 1'b0),
               mk_lo(p0 | 20'h40000, 3'(i + 1), 1'b1, 1'b1, 1'b0),
               size_mask(i % 7));
        end
        for (int i = 0; i < N; i++) readback("R2 readback", i);

        // R6 R4: every slot, both halves, load and store, plus wrong ASID
        for (int i = 0; i < N; i++) begin
            int k;
            k = 2 * (i % 7);
            for (int odd = 0; odd < 2; odd++) begin
                for (int st = 0; st < 2; st++) begin
                    logic [31:0] va;
                    va = (32'(i) << 25) | (32'(odd) << (12 + k))
                       | (32'h00A5_5A5A & ((32'd1 << (12 + k)) - 1));
                    look("R6 translate", va, 8'(i + 3), st[0]);
                end
            end
            look("R4 wrong asid", 32'(i) << 25, 8'(i + 100), 1'b0);
            look("R6 unmasked tag bit", (32'(i) << 25) | 32'h0100_0000, 8'(i + 3), 1'b0);
        end

        // R3: no result in the cycle after an idle cycle
        @(negedge clk);
        chk("R3 idle no result", 64'(res_valid), 64'd0);

        // R5: both global bits set ignores ASID; one global bit does not
        wr(0, 19'h0, 8'd3, mk_lo(20'h12345, 3'd3, 1'b1, 1'b1, 1'b1),
           mk_lo(20'h12346, 3'd2, 1'b1, 1'b1, 1'b1), 12'h000);
        look("R5 global any asid", 32'h0000_0ABC, 8'd77, 1'b0);
        wr(1, 19'(1 << 12), 8'd4, mk_lo(20'h22222, 3'd1, 1'b1, 1'b1, 1'b1),
           mk_lo(20'h33333, 3'd1, 1'b1, 1'b1, 1'b0), 12'h003);
        look("R5 half global still tagged", 32'h0200_0000, 8'd77, 1'b0);
        readback("R5 readback global", 0);
        readback("R5 readback half global", 1);

        // R4: same VPN2, two ASIDs coexist
        wr(10, m_vpn2[3], 8'd55, mk_lo(20'h0ABCD, 3'd5, 1'b1, 1'b1, 1'b0),
           mk_lo(20'h0BCDE, 3'd5, 1'b1, 1'b1, 1'b0), m_mask[3]);
        look("R4 coexist first asid", 32'h0600_0100, 8'd6, 1'b0);
        look("R4 coexist second asid", 32'h0600_0100, 8'd55, 1'b0);

        // R7: invalid page and modify fault
        wr(6, 19'(6 << 12), 8'd9, mk_lo(20'h44444, 3'd2, 1'b0, 1'b1, 1'b0),
           mk_lo(20'h55555, 3'd2, 1'b1, 1'b0, 1'b0), 12'h000);
        look("R7 odd invalid", 32'h0C00_1004, 8'd9, 1'b0);
        look("R7 store clean modify", 32'h0C00_0004, 8'd9, 1'b1);
        look("R7 load clean ok", 32'h0C00_0004, 8'd9, 1'b0);

        // R9: overlapping slots, lowest index wins
        wr(9, m_vpn2[2], m_asid[2], mk_lo(20'h77777, 3'd7, 1'b1, 1'b1, 1'b0),
           mk_lo(20'h66666, 3'd6, 1'b1, 1'b1, 1'b0), m_mask[2]);
        look("R9 lowest index", 32'h0400_0123, m_asid[2], 1'b0);
        look("R9 lowest index odd", 32'h0401_0123, m_asid[2], 1'b0);

        // R8: lookup in the write cycle sees old contents, next cycle sees new
        begin
            logic h, v, d; logic [31:0] pa; logic [2:0] c; logic [1:0] f;
            model(32'h0A00_0040, 8'd50, 1'b0, h, pa, v, d, c, f);
            lk_valid = 1; lk_va = 32'h0A00_0040; lk_asid = 8'd50; lk_store = 0;
            wr_en = 1; wr_index = 4'd5; wr_vpn2 = 19'(5 << 12); wr_asid = 8'd50;
            wr_lo0 = mk_lo(20'h9ABCD, 3'd4, 1'b1, 1'b1, 1'b0);
            wr_lo1 = mk_lo(20'h9ABCE, 3'd4, 1'b1, 1'b1, 1'b0); wr_mask = 12'h000;
            @(negedge clk);
            wr_en = 0; lk_valid = 0;
            chk("R8 same cycle old hit", 64'(res_hit), 64'(h));
            chk("R8 same cycle old fault", 64'(res_fault), 64'(f));
            m_vpn2[5] = 19'(5 << 12); m_asid[5] = 8'd50; m_mask[5] = 12'h000;
            m_lo0[5] = mk_lo(20'h9ABCD, 3'd4, 1'b1, 1'b1, 1'b0);
            m_lo1[5] = mk_lo(20'h9ABCE, 3'd4, 1'b1, 1'b1, 1'b0);
        end
        look("R8 next cycle new", 32'h0A00_0040, 8'd50, 1'b0);
        look("R8 old asid gone", 32'h0A00_0040, 8'd8, 1'b0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule